// File: doc/BRIEF.md
# Indirect Data Addressing Unit

This block turns the register operand of an 8-bit register-file core into a data-memory address. A nonzero operand is a direct access: two bank-select bits sit above the 7-bit operand field. Operand zero names a virtual register that has no storage. An access to it is steered to the location held in an 8-bit pointer register, and the indirect bank bit supplied by the status logic is placed above the pointer to form a 9-bit address.

The pointer register lives inside the block at a fixed file address, which is mirrored in every bank. Accesses to that address, direct or indirect, are served by the block and do not reach the RAM. If the pointer itself selects the virtual register (low seven bits zero), the access points back at itself. Such a read returns 0x00 and such a write is dropped. Addresses are resolved combinationally within the access cycle, so a pointer write is used by the following instruction. The block gives no indication of whether an access was indirect. The RAM array and the status flags are outside the block.

Top module: `idau_core`

## Requirements
- R1: With a nonzero operand, the RAM address is {dir_bank, op_addr} (dir_bank in bits 8:7).
- R2: With operand 0x00, the RAM address is {ind_bank, pointer} (ind_bank in bit 8).
- R3: An indirect read whose pointer has bits 6:0 equal to zero returns 0x00 on rd_data and leaves ram_rd low.
- R4: An indirect write whose pointer has bits 6:0 equal to zero leaves ram_wr low and leaves the pointer unchanged.
- R5: A write whose effective address has bits 6:0 equal to 0x04 (in any bank, direct or indirect) loads wr_data into the pointer at the next clock edge, and ram_wr stays low.
- R6: A read whose effective address has bits 6:0 equal to 0x04 returns the pointer value and leaves ram_rd low.
- R7: Reset clears the pointer to 0x00.
- R8: Other accesses pass rd_en and wr_en through to ram_rd and ram_wr, drive ram_wdata with wr_data and return ram_rdata. rd_data is 0x00 whenever rd_en is low.
- R9: An indirect access in the cycle after a pointer write uses the new pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_addr | input | 7 | Register operand of the instruction |
| dir_bank | input | 2 | Bank bits for direct accesses |
| ind_bank | input | 1 | Bank bit for indirect accesses |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| ram_rdata | input | 8 | Data returned by the RAM |
| ram_addr | output | 9 | Effective RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| rd_data | output | 8 | Read data to the core |
| ptr_out | output | 8 | Current pointer value |

## Verification
Direct operands are tried at the low, middle and top of the field in several banks, which separates the bank bits from the operand bits. Indirect accesses are tried with both values of the indirect bank bit, so that a swapped bank source shows up. The pointer is set to 0x00 and to 0x80 to reach the self-reference case in both halves of its range. The pointer is also written both directly and through itself, and is then used in the very next cycle, which exposes a stale pointer or a write that leaks into the RAM.

// File: rtl/idau_pkg.sv
package idau_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_SELF     = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/idau_addr_mux.sv
module idau_addr_mux
  import idau_pkg::*;
#(
  parameter int OP_W   = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  localparam int ADDR_W = BANK_W + OP_W
) (
  input  logic [OP_W-1:0]   op,
  input  logic [BANK_W-1:0] bank,
  input  logic              ibank,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] eff_addr,
  output acc_kind_e         kind
);
  logic is_ind;
  logic ptr_self;

  always_comb begin
    is_ind   = (op == '0);
    ptr_self = (ptr[OP_W-1:0] == '0);
    if (!is_ind) begin
      eff_addr = {bank, op};
      kind     = ACC_DIRECT;
    end else begin
      eff_addr = {ibank, ptr};
      kind     = ptr_self ? ACC_SELF : ACC_INDIRECT;
    end
  end

  always_comb begin
    if (kind == ACC_DIRECT)
      AST_DIRECT_NONZERO: assert (eff_addr[OP_W-1:0] != '0); // R1
  end
endmodule

// File: rtl/idau_guard.sv
module idau_guard
  import idau_pkg::*;
#(
  parameter int OP_W    = 7,
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 8,
  parameter int PTR_LOC = 4
) (
  input  acc_kind_e         kind,
  input  logic [OP_W-1:0]   loc,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [PTR_W-1:0]  ptr_q,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic              ptr_we,
  output logic [DATA_W-1:0] rd_data
);
  logic is_self;
  logic is_ptr;
  logic to_ram;

  always_comb begin
    is_self = (kind == ACC_SELF);
    is_ptr  = !is_self && (loc == OP_W'(PTR_LOC));
    to_ram  = !is_self && !is_ptr;
    ram_rd  = rd_en && to_ram;
    ram_wr  = wr_en && to_ram;
    ptr_we  = wr_en && is_ptr;
    if (!rd_en || is_self)
      rd_data = '0;
    else if (is_ptr)
      rd_data = DATA_W'(ptr_q);
    else
      rd_data = ram_rdata;
  end

  always_comb begin
    if (is_self && rd_en)
      AST_SELF_READ_ZERO: assert (rd_data == '0 && !ram_rd); // R3
    if (is_self && wr_en)
      AST_SELF_WRITE_DROP: assert (!ram_wr && !ptr_we); // R4
  end
endmodule

// File: rtl/idau_ptr_reg.sv
module idau_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] d,
  output logic [PTR_W-1:0] q
);
  logic [PTR_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R4
endmodule

// File: rtl/idau_core.sv
module idau_core
  import idau_pkg::*;
#(
  parameter int OP_W    = 7,
  parameter int BANK_W  = 2,
  parameter int PTR_W   = 8,
  parameter int DATA_W  = 8,
  parameter int PTR_LOC = 4,
  localparam int ADDR_W = BANK_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_addr,
  input  logic [BANK_W-1:0] dir_bank,
  input  logic              ind_bank,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr_out
);
  acc_kind_e        kind;
  logic             ptr_we;
  logic [PTR_W-1:0] ptr_q;

  idau_addr_mux #(.OP_W(OP_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) u_mux (
    .op(op_addr), .bank(dir_bank), .ibank(ind_bank), .ptr(ptr_q),
    .eff_addr(ram_addr), .kind(kind)
  );

  idau_guard #(.OP_W(OP_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .PTR_LOC(PTR_LOC)) u_guard (
    .kind(kind), .loc(ram_addr[OP_W-1:0]), .rd_en(rd_en), .wr_en(wr_en),
    .ram_rdata(ram_rdata), .ptr_q(ptr_q), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ptr_we(ptr_we), .rd_data(rd_data)
  );

  idau_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(ptr_we), .d(PTR_W'(wr_data)), .q(ptr_q)
  );

  assign ram_wdata = wr_data;
  assign ptr_out   = ptr_q;

  AST_RAM_WR_NOT_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> ram_addr[OP_W-1:0] != '0); // R4
  AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_addr == '0) |-> ram_addr == {ind_bank, ptr_out}); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0); // R8
  AST_PTR_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr[OP_W-1:0] == OP_W'(PTR_LOC)) |-> !ram_rd && !ram_wr); // R6
endmodule

// File: tb/sim_idau_core.sv
module sim_idau_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] op_addr = '0;
  logic [1:0] dir_bank = '0;
  logic       ind_bank = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ram_rdata = '0;
  logic [8:0] ram_addr;
  logic       ram_rd, ram_wr;
  logic [7:0] ram_wdata, rd_data, ptr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idau_core u0 (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .dir_bank(dir_bank),
    .ind_bank(ind_bank), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_wdata(ram_wdata), .rd_data(rd_data), .ptr_out(ptr_out)
  );

  // {op7, bank2, ib1, rd1, wr1, ramdata8, exp_addr9, exp_rd1, exp_wr1, exp_rdata8}
  // Pointer preset to 0x3A, wr_data 0x5C.
  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {7'h20, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 9'h0A0, 1'b1, 1'b0, 8'h11}, // R1 R8
    {7'h7F, 2'd3, 1'b0, 1'b0, 1'b1, 8'h00, 9'h1FF, 1'b0, 1'b1, 8'h00}, // R1 R8
    {7'h00, 2'd2, 1'b0, 1'b1, 1'b0, 8'h22, 9'h03A, 1'b1, 1'b0, 8'h22}, // R2
    {7'h00, 2'd0, 1'b1, 1'b0, 1'b1, 8'h00, 9'h13A, 1'b0, 1'b1, 8'h00}, // R2
    {7'h04, 2'd2, 1'b0, 1'b1, 1'b0, 8'h99, 9'h104, 1'b0, 1'b0, 8'h3A}, // R6
    {7'h10, 2'd0, 1'b0, 1'b0, 1'b0, 8'h77, 9'h010, 1'b0, 1'b0, 8'h00}  // R8
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] op, input logic [1:0] bk, input logic ib,
                       input logic rd, input logic wr, input logic [7:0] wd,
                       input logic [7:0] rr);
    @(negedge clk);
    op_addr = op; dir_bank = bk; ind_bank = ib; rd_en = rd; wr_en = wr;
    wr_data = wd; ram_rdata = rr;
    #1;
  endtask

  task automatic idle();
    drive(7'h10, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset pointer", ptr_out, 8'h00);
    rst_n = 1'b1;
    // Self reference with pointer 0x00
    drive(7'h00, 2'd1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hAB);
    chk("R3 self read data", rd_data, 8'h00);
    chk("R3 self read strobe", ram_rd, 0);
    drive(7'h00, 2'd1, 1'b0, 1'b0, 1'b1, 8'hEE, 8'h00);
    chk("R4 self write strobe", ram_wr, 0);
    idle();
    chk("R4 pointer unchanged", ptr_out, 8'h00);
    // Direct write of the pointer, then immediate use
    drive(7'h04, 2'd3, 1'b0, 1'b0, 1'b1, 8'h3A, 8'h00);
    chk("R5 pointer write no ram_wr", ram_wr, 0);
    drive(7'h00, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h42);
    chk("R5 pointer loaded", ptr_out, 8'h3A);
    chk("R9 next access uses new pointer", ram_addr, 9'h13A);
    chk("R9 next access data", rd_data, 8'h42);
    // Table walk with pointer 0x3A
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      drive(v[38:32], v[31:30], v[29], v[28], v[27], 8'h5C, v[26:19]);
      chk($sformatf("R1/R2/R6/R8 vec%0d addr", i), ram_addr, v[18:10]);
      chk($sformatf("R8 vec%0d ram_rd", i), ram_rd, v[9]);
      chk($sformatf("R8 vec%0d ram_wr", i), ram_wr, v[8]);
      chk($sformatf("R8 vec%0d rd_data", i), rd_data, v[7:0]);
      if (v[8]) chk($sformatf("R8 vec%0d wdata", i), ram_wdata, 8'h5C);
    end
    idle();
    chk("R8 table writes leave pointer", ptr_out, 8'h3A);
    // Pointer 0x80: self in upper half
    drive(7'h04, 2'd0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h00);
    drive(7'h00, 2'd2, 1'b1, 1'b1, 1'b1, 8'h66, 8'hCD);
    chk("R3 self read 0x80 data", rd_data, 8'h00);
    chk("R3 self read 0x80 strobe", ram_rd, 0);
    chk("R4 self write 0x80 strobe", ram_wr, 0);
    idle();
    chk("R4 pointer kept 0x80", ptr_out, 8'h80);
    // Indirect write to pointer through itself (pointer 0x84)
    drive(7'h04, 2'd1, 1'b0, 1'b0, 1'b1, 8'h84, 8'h00);
    drive(7'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11);
    chk("R6 indirect read of pointer", rd_data, 8'h84);
    chk("R6 indirect read no ram_rd", ram_rd, 0);
    drive(7'h00, 2'd0, 1'b1, 1'b0, 1'b1, 8'h55, 8'h00);
    chk("R5 indirect pointer write no ram_wr", ram_wr, 0);
    idle();
    chk("R5 indirect pointer loaded", ptr_out, 8'h55);
    // Reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 async reset clears pointer", ptr_out, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule